// File: doc/BRIEF.md
# Burst-of-Four Quad-Data-Rate SRAM Controller

This block sits between on-chip logic and a static memory that has independent read and write data ports and moves every access as a fixed burst of four words. A write request carries all four words and a per-word lane-enable mask in one transfer. The controller then drives the active-low write select and the write address, and spreads the four words over two clock cycles as rise/fall pairs. Each word carries its own active-low lane mask. A read request drives the active-low read select and the read address. After a fixed latency the four returned words arrive as two first/second pairs on consecutive cycles, and the controller gathers them into one response.

Double-data-rate transfer is modelled as two data lanes per cycle: one for the clock's rising edge and one for its falling edge. The two ports work independently. Each port issues at most one command every two cycles, so the selects are never low on two consecutive cycles. Reads are tagged in request order and answered in that same order. The number of reads in flight is limited by a parameter.

Top module: `qdr_b4_ctrl`

## Requirements
- R1: While `rst` is high, `mem_rd_n` and `mem_wr_n` are 1, every bit of `mem_bw_rise_n` and `mem_bw_fall_n` is 1, and `wr_ready`, `rd_ready` and `rsp_valid` are 0.
- R2: A write is accepted on a rising edge where `wr_valid` and `wr_ready` are both 1. In the following cycle the outputs are as follows. `mem_wr_n` is 0 and `mem_wr_addr` equals the request address. `mem_d_rise` carries word 0 and `mem_d_fall` carries word 1. `mem_bw_rise_n` carries the inverted mask of beat 0 and `mem_bw_fall_n` the inverted mask of beat 1. `wr_ready` is 0. Word k is `wr_data[k*DATA_W +: DATA_W]`. The mask of beat k is `wr_be[k*BW_N +: BW_N]`, and a 1 in that mask enables the lane.
- R3: In the cycle after that, `mem_wr_n` is 1. `mem_d_rise` and `mem_d_fall` carry words 2 and 3. `mem_bw_rise_n` and `mem_bw_fall_n` carry the inverted masks of beats 2 and 3.
- R4: A read is accepted when `rd_valid` and `rd_ready` are both 1. In the following cycle `mem_rd_n` is 0, `mem_rd_addr` equals the request address and `rd_ready` is 0. In the cycle after that `mem_rd_n` is 1 again.
- R5: In any cycle that carries no write word, `mem_wr_n` is 1 and all lane masks are 1, so nothing is written.
- R6: A lane is 4 bits wide when `DATA_W` is 8 and 9 bits wide otherwise. There are `BW_N = DATA_W/lane` lanes, and mask bit j covers data bits `[j*lane +: lane]`. A beat whose mask is all 0 leaves the memory word unchanged.
- R7: Let c be the cycle in which `mem_rd_n` is 0. Words 0 and 1 are taken from `mem_q_a` and `mem_q_b` in cycle c+RD_LAT. Words 2 and 3 are taken from the same lanes in cycle c+RD_LAT+1. `rsp_valid` is 1 for exactly one cycle, c+RD_LAT+2, and word k is then at `rsp_data[k*DATA_W +: DATA_W]`.
- R8: `rd_tag` shows the tag given to the read being accepted. The tag starts at 0 after reset, rises by 1 modulo 2^TAG_W for each accepted read, and comes back on `rsp_tag` with the response in request order.
- R9: A read and a write can be accepted on the same edge, so both selects can be low in the same cycle.
- R10: If `wr_valid` stays high, writes are accepted exactly two cycles apart. Two reads are never accepted less than two cycles apart.
- R11: If QDEPTH reads are outstanding and no response is being delivered in the current cycle, `rd_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted when high |
| wr_addr | input | ADDR_W | Burst address of the write |
| wr_data | input | 4*DATA_W | Four write words, word 0 lowest |
| wr_be | input | 4*BW_N | Per-beat lane enables, beat 0 lowest |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted when high |
| rd_addr | input | ADDR_W | Burst address of the read |
| rd_tag | output | TAG_W | Tag given to the read being accepted |
| rsp_valid | output | 1 | Read response valid, one cycle |
| rsp_data | output | 4*DATA_W | Four read words, word 0 lowest |
| rsp_tag | output | TAG_W | Tag of the response |
| mem_wr_n | output | 1 | Write select, active low |
| mem_wr_addr | output | ADDR_W | Write address to memory |
| mem_d_rise | output | DATA_W | Write word for the rising edge |
| mem_d_fall | output | DATA_W | Write word for the falling edge |
| mem_bw_rise_n | output | BW_N | Lane selects for the rising-edge word, active low |
| mem_bw_fall_n | output | BW_N | Lane selects for the falling-edge word, active low |
| mem_rd_n | output | 1 | Read select, active low |
| mem_rd_addr | output | ADDR_W | Read address to memory |
| mem_q_a | input | DATA_W | First word of each returned pair |
| mem_q_b | input | DATA_W | Second word of each returned pair |

## Verification
The bench targets back-to-back bursts on both ports. A controller that let a select stay low for two cycles would issue a command the memory ignores, and a spurious third write pair would corrupt a neighbouring burst. Partial and all-zero lane masks on single beats are written and read back. Swapped beat masks or swapped rise/fall words would show up as a corrupted half-lane. Reads are run into the depth limit and across the tag wrap, and are overlapped with writes in the same cycle. Here an off-by-one capture cycle, out-of-order tags or an overfilled queue would produce a response that does not match.

// File: rtl/qdr_b4_ctrl.sv
module qdr_b4_ctrl #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 18,
  parameter int RD_LAT = 3,
  parameter int QDEPTH = 4,
  parameter int TAG_W  = 4,
  localparam int LANE_W = (DATA_W == 8) ? 4 : 9,
  localparam int BW_N   = DATA_W / LANE_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [4*DATA_W-1:0]   wr_data,
  input  logic [4*BW_N-1:0]     wr_be,
  input  logic                  rd_valid,
  output logic                  rd_ready,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [TAG_W-1:0]      rd_tag,
  output logic                  rsp_valid,
  output logic [4*DATA_W-1:0]   rsp_data,
  output logic [TAG_W-1:0]      rsp_tag,
  output logic                  mem_wr_n,
  output logic [ADDR_W-1:0]     mem_wr_addr,
  output logic [DATA_W-1:0]     mem_d_rise,
  output logic [DATA_W-1:0]     mem_d_fall,
  output logic [BW_N-1:0]       mem_bw_rise_n,
  output logic [BW_N-1:0]       mem_bw_fall_n,
  output logic                  mem_rd_n,
  output logic [ADDR_W-1:0]     mem_rd_addr,
  input  logic [DATA_W-1:0]     mem_q_a,
  input  logic [DATA_W-1:0]     mem_q_b
);
  localparam int CW = $clog2(QDEPTH + 1);

  logic                   wr_ph;
  logic [2*DATA_W-1:0]    wr_hi_d;
  logic [2*BW_N-1:0]      wr_hi_m;
  logic                   wr_go;

  logic                   rd_ph;
  logic                   rd_go;
  logic [CW-1:0]          out_cnt;
  logic [TAG_W-1:0]       iss_tag;
  logic [TAG_W-1:0]       ret_tag;
  logic [RD_LAT:0]        ret_sr;
  logic [2*DATA_W-1:0]    cap_lo;

  assign wr_ready = !rst && !wr_ph;
  assign wr_go    = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ph         <= 1'b0;
      mem_wr_n      <= 1'b1;
      mem_wr_addr   <= '0;
      mem_d_rise    <= '0;
      mem_d_fall    <= '0;
      mem_bw_rise_n <= '1;
      mem_bw_fall_n <= '1;
      wr_hi_d       <= '0;
      wr_hi_m       <= '0;
    end else if (wr_go) begin
      wr_ph         <= 1'b1;
      mem_wr_n      <= 1'b0;
      mem_wr_addr   <= wr_addr;
      mem_d_rise    <= wr_data[0 +: DATA_W];
      mem_d_fall    <= wr_data[DATA_W +: DATA_W];
      mem_bw_rise_n <= ~wr_be[0 +: BW_N];
      mem_bw_fall_n <= ~wr_be[BW_N +: BW_N];
      wr_hi_d       <= wr_data[2*DATA_W +: 2*DATA_W];
      wr_hi_m       <= wr_be[2*BW_N +: 2*BW_N];
    end else if (wr_ph) begin
      wr_ph         <= 1'b0;
      mem_wr_n      <= 1'b1;
      mem_d_rise    <= wr_hi_d[0 +: DATA_W];
      mem_d_fall    <= wr_hi_d[DATA_W +: DATA_W];
      mem_bw_rise_n <= ~wr_hi_m[0 +: BW_N];
      mem_bw_fall_n <= ~wr_hi_m[BW_N +: BW_N];
    end else begin
      mem_wr_n      <= 1'b1;
      mem_d_rise    <= '0;
      mem_d_fall    <= '0;
      mem_bw_rise_n <= '1;
      mem_bw_fall_n <= '1;
    end
  end

  assign rd_ready = !rst && !rd_ph && ((out_cnt < CW'(QDEPTH)) || rsp_valid);
  assign rd_go    = rd_valid && rd_ready;
  assign rd_tag   = iss_tag;
  assign rsp_tag  = ret_tag;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ph       <= 1'b0;
      mem_rd_n    <= 1'b1;
      mem_rd_addr <= '0;
      iss_tag     <= '0;
      ret_tag     <= '0;
      out_cnt     <= '0;
      ret_sr      <= '0;
      cap_lo      <= '0;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
    end else begin
      rd_ph    <= rd_go;
      mem_rd_n <= !rd_go;
      if (rd_go) begin
        mem_rd_addr <= rd_addr;
        iss_tag     <= iss_tag + 1'b1;
      end
      if (rsp_valid) ret_tag <= ret_tag + 1'b1;
      out_cnt <= out_cnt + CW'(rd_go) - CW'(rsp_valid);
      ret_sr  <= {ret_sr[RD_LAT-1:0], !mem_rd_n};
      if (ret_sr[RD_LAT-1]) cap_lo <= {mem_q_b, mem_q_a};
      rsp_valid <= ret_sr[RD_LAT];
      if (ret_sr[RD_LAT]) rsp_data <= {mem_q_b, mem_q_a, cap_lo};
    end
  end

  // R4
  rd_gap_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_rd_n |=> mem_rd_n);

  // R3
  wr_gap_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_wr_n |=> mem_wr_n);

  // R7
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R5
  idle_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_n && !$past(!mem_wr_n)) |-> (&mem_bw_rise_n && &mem_bw_fall_n));

  // R11
  depth_chk: assert property (@(posedge clk) disable iff (rst)
    out_cnt <= CW'(QDEPTH));

  // R8
  tag_step_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> (rsp_tag == $past(rsp_tag) + 1'b1));
endmodule

// File: tb/test_qdr_b4_ctrl.sv
module test_qdr_b4_ctrl;
  localparam int AW = 4, DW = 18, LAT = 3, QD = 2, TW = 3, LW = 9, BN = 2;

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic wr_valid = 1'b0, rd_valid = 1'b0;
  logic wr_ready, rd_ready, rsp_valid;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0, mem_wr_addr, mem_rd_addr;
  logic [4*DW-1:0] wr_data = '0, rsp_data;
  logic [4*BN-1:0] wr_be = '0;
  logic [TW-1:0] rd_tag, rsp_tag;
  logic mem_wr_n, mem_rd_n;
  logic [DW-1:0] mem_d_rise, mem_d_fall, mem_q_a, mem_q_b;
  logic [BN-1:0] mem_bw_rise_n, mem_bw_fall_n;

  qdr_b4_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(LAT), .QDEPTH(QD), .TAG_W(TW)) i_qdr_b4_ctrl (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_tag(rd_tag),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_tag(rsp_tag),
    .mem_wr_n(mem_wr_n), .mem_wr_addr(mem_wr_addr), .mem_d_rise(mem_d_rise), .mem_d_fall(mem_d_fall),
    .mem_bw_rise_n(mem_bw_rise_n), .mem_bw_fall_n(mem_bw_fall_n),
    .mem_rd_n(mem_rd_n), .mem_rd_addr(mem_rd_addr), .mem_q_a(mem_q_a), .mem_q_b(mem_q_b));

  int checks = 0, fails = 0, cyc = 0;
  logic run = 1'b0;

  task automatic chk(input logic ok, input string req, input logic [4*DW-1:0] act, input logic [4*DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model
  logic [DW-1:0] mdl [16][4];
  logic [DW-1:0] exp_mem [16][4];
  logic wpend = 1'b0;
  logic [AW-1:0] wa;
  logic pv [LAT+1];
  logic [AW-1:0] pa [LAT+1];

  initial begin
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 4; b++) begin mdl[a][b] = '0; exp_mem[a][b] = '0; end
    for (int i = 0; i <= LAT; i++) begin pv[i] = 1'b0; pa[i] = '0; end
  end

  task automatic mdl_put(input logic [AW-1:0] a, input int b, input logic [DW-1:0] d, input logic [BN-1:0] bwn);
    for (int j = 0; j < BN; j++)
      if (!bwn[j]) mdl[a][b][j*LW +: LW] = d[j*LW +: LW];
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (wpend) begin
      mdl_put(wa, 2, mem_d_rise, mem_bw_rise_n);
      mdl_put(wa, 3, mem_d_fall, mem_bw_fall_n);
    end
    if (!mem_wr_n) begin
      mdl_put(mem_wr_addr, 0, mem_d_rise, mem_bw_rise_n);
      mdl_put(mem_wr_addr, 1, mem_d_fall, mem_bw_fall_n);
    end
    wpend <= !mem_wr_n;
    wa <= mem_wr_addr;
    for (int i = LAT; i > 0; i--) begin pv[i] <= pv[i-1]; pa[i] <= pa[i-1]; end
    pv[0] <= !mem_rd_n;
    pa[0] <= mem_rd_addr;
  end

  assign mem_q_a = pv[LAT-1] ? mdl[pa[LAT-1]][0] : (pv[LAT] ? mdl[pa[LAT]][2] : '0);
  assign mem_q_b = pv[LAT-1] ? mdl[pa[LAT-1]][1] : (pv[LAT] ? mdl[pa[LAT]][3] : '0);

  function automatic logic [DW-1:0] wword(input int a, input int b, input int p);
    return DW'((a * 1031 + b * 263 + p * 4099 + 77) ^ (a << 9));
  endfunction
  function automatic logic [BN-1:0] wmask(input int a, input int b, input int p);
    return (p == 0) ? 2'b11 : BN'((a + b + p) % 4);
  endfunction

  // expected read queue
  logic [4*DW-1:0] eq_data [64];
  logic [TW-1:0] eq_tag [64];
  int eq_cyc [64];
  int eq_wp = 0, eq_rp = 0;
  logic [TW-1:0] etag = '0;
  int acc_rd = 0, done_rd = 0;
  int last_wr = -100, last_rd = -100;
  int both_seen = 0;
  logic [DW-1:0] hi_d2, hi_d3;
  logic [BN-1:0] hi_b2, hi_b3;
  logic prev_wr_low = 1'b0, prev_rd_low = 1'b0;

  always @(posedge clk) begin
    if (rsp_valid) done_rd <= done_rd + 1;
  end

  always @(negedge clk) if (run) begin
    if (prev_wr_low) begin
      // R3
      chk(mem_wr_n && mem_d_rise == hi_d2 && mem_d_fall == hi_d3 &&
          mem_bw_rise_n == ~hi_b2 && mem_bw_fall_n == ~hi_b3, "R3",
          {mem_wr_n, mem_bw_fall_n, mem_bw_rise_n, mem_d_fall, mem_d_rise},
          {1'b1, ~hi_b3, ~hi_b2, hi_d3, hi_d2});
    end else if (mem_wr_n) begin
      // R5
      chk(&mem_bw_rise_n && &mem_bw_fall_n, "R5", {mem_bw_fall_n, mem_bw_rise_n}, '1);
    end
    if (!mem_rd_n) chk(!rd_ready, "R4 ready low", 72'(rd_ready), 72'(0));
    if (prev_rd_low) chk(mem_rd_n, "R4 select released", 72'(mem_rd_n), 72'(1));
    if (acc_rd - done_rd >= QD && !rsp_valid)
      chk(!rd_ready, "R11", 72'(rd_ready), 72'(0));
    chk(acc_rd - done_rd <= QD, "R11 depth", 72'(acc_rd - done_rd), 72'(QD));
    if (!mem_rd_n && !mem_wr_n) both_seen++;
    if (rsp_valid) begin
      if (eq_rp == eq_wp) chk(1'b0, "R7 unexpected response", rsp_data, '0);
      else begin
        chk(rsp_data == eq_data[eq_rp], "R7 data", rsp_data, eq_data[eq_rp]);
        chk(rsp_tag == eq_tag[eq_rp], "R8 tag", 72'(rsp_tag), 72'(eq_tag[eq_rp]));
        chk(cyc - eq_cyc[eq_rp] == LAT + 2, "R7 timing", 72'(cyc - eq_cyc[eq_rp]), 72'(LAT + 2));
        eq_rp++;
      end
    end
    prev_wr_low = !mem_wr_n;
    prev_rd_low = !mem_rd_n;
  end

  task automatic do_write(input int a, input int p, input logic b2b);
    logic [4*DW-1:0] d;
    logic [4*BN-1:0] m;
    for (int b = 0; b < 4; b++) begin
      d[b*DW +: DW] = wword(a, b, p);
      m[b*BN +: BN] = wmask(a, b, p);
    end
    wr_addr = AW'(a); wr_data = d; wr_be = m; wr_valid = 1'b1;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    for (int b = 0; b < 4; b++)
      for (int j = 0; j < BN; j++)
        if (m[b*BN + j]) exp_mem[a][b][j*LW +: LW] = d[b*DW + j*LW +: LW];
    hi_d2 = d[2*DW +: DW]; hi_d3 = d[3*DW +: DW];
    hi_b2 = m[2*BN +: BN]; hi_b3 = m[3*BN +: BN];
    // R2
    chk(!mem_wr_n && mem_wr_addr == AW'(a) && mem_d_rise == d[0 +: DW] && mem_d_fall == d[DW +: DW] &&
        mem_bw_rise_n == ~m[0 +: BN] && mem_bw_fall_n == ~m[BN +: BN] && !wr_ready, "R2",
        {wr_ready, mem_wr_n, mem_bw_fall_n, mem_bw_rise_n, mem_wr_addr, mem_d_fall, mem_d_rise},
        {1'b0, 1'b0, ~m[BN +: BN], ~m[0 +: BN], AW'(a), d[DW +: DW], d[0 +: DW]});
    if (b2b) chk(cyc - last_wr == 2, "R10 write spacing", 72'(cyc - last_wr), 72'(2));
    last_wr = cyc;
  endtask

  task automatic do_read(input int a);
    rd_addr = AW'(a); rd_valid = 1'b1;
    while (!rd_ready) @(negedge clk);
    // R8
    chk(rd_tag == etag, "R8 issue tag", 72'(rd_tag), 72'(etag));
    @(posedge clk);
    acc_rd++;
    eq_data[eq_wp] = {exp_mem[a][3], exp_mem[a][2], exp_mem[a][1], exp_mem[a][0]};
    eq_tag[eq_wp] = etag;
    etag = etag + 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    eq_cyc[eq_wp] = cyc;
    eq_wp++;
    chk(!mem_rd_n && mem_rd_addr == AW'(a), "R4 issue", {mem_rd_n, mem_rd_addr}, {1'b0, AW'(a)});
    chk(cyc - last_rd >= 2, "R10 read spacing", 72'(cyc - last_rd), 72'(2));
    last_rd = cyc;
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && eq_rp != eq_wp; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(eq_rp == eq_wp, "R7 all responses", 72'(eq_rp), 72'(eq_wp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1
    chk(mem_rd_n && mem_wr_n && &mem_bw_rise_n && &mem_bw_fall_n, "R1 selects",
        {mem_rd_n, mem_wr_n, mem_bw_fall_n, mem_bw_rise_n}, '1);
    chk(!wr_ready && !rd_ready && !rsp_valid, "R1 handshake",
        {wr_ready, rd_ready, rsp_valid}, '0);
    wr_valid = 1'b1; rd_valid = 1'b1;
    @(negedge clk);
    chk(mem_rd_n && mem_wr_n && !wr_ready && !rd_ready, "R1 held off",
        {mem_rd_n, mem_wr_n, wr_ready, rd_ready}, {1'b1, 1'b1, 1'b0, 1'b0});
    wr_valid = 1'b0; rd_valid = 1'b0;
    rst = 1'b0;
    run = 1'b1;
    repeat (3) @(negedge clk);
    chk(mem_rd_n && mem_wr_n, "R5 idle selects", {mem_rd_n, mem_wr_n}, 2'b11);
    chk(rd_tag == '0, "R8 reset tag", 72'(rd_tag), 72'(0));

    // full writes back to back, then masked writes back to back (R6, R10)
    for (int a = 0; a < 16; a++) do_write(a, 0, a != 0);
    for (int a = 0; a < 16; a++) do_write(a, 1, a != 0);
    repeat (3) @(negedge clk);
    // R6: all reads follow the masked merge
    for (int a = 0; a < 16; a++) do_read(a);
    drain();

    // R9: concurrent read and write on separate addresses
    for (int a = 0; a < 8; a++) begin
      fork
        do_write(a, 2, 1'b0);
        do_read(8 + a);
      join
    end
    drain();
    chk(both_seen > 0, "R9 same-cycle issue", 72'(both_seen), 72'(1));
    for (int a = 0; a < 8; a++) do_read(a);
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule